// File: doc/BRIEF.md
# Watchdog Secondary Status Register

This block is a 16-bit status register placed next to a watchdog timer. It collects four event indications: a system-management interrupt message received on a management link, the no-reboot strap value, a second watchdog expiry, and a chassis intrusion. Each event bit is sticky and is cleared by software writing 1 to its position. The strap bit can only be read.

The bits belong to three reset domains. The intrusion bit follows the RTC-well reset. The link-message, second-expiry and strap bits follow the resume-well reset. The platform reset clears only the internal first-expiry flag, so the bits that explain why the platform reset happened are still there after it. When a second expiry is recorded and the reboot-inhibit control is low, the block issues a fixed-length platform reset request.

The watchdog counter and the link decoder are outside this block. They deliver a timeout pulse, a reload-write strobe and a decoded command type. Every reset input is asserted asynchronously and released through a synchronizer. The intrusion, power-good and strap pins pass through synchronizer stages before they are used.

Top module: `wdt2_status`

## Requirements
- R1: Bits 15:5 and bit 3 of `rd_data` always read 0, and writing 1 to them has no effect.
- R2: Bit 4 sets one clock after a cycle with `link_cmd_vld` high and `link_cmd_type` equal to 8'h08. Other command types leave it unchanged. Writing 1 to bit 4 clears it.
- R3: Bits 4 and 1 keep their values through a platform reset (`plt_rst_n`). A resume-well reset (`rsm_rst_n`) clears them.
- R4: Bit 2 takes the value of `noreboot_strap` when a rising edge of `pwr_good` is detected, two synchronizer clocks after the edge. It holds that value at all other times, ignores writes, and is cleared by the resume-well reset.
- R5: Bit 1 sets one clock after a `wdt_timeout` pulse, provided an earlier timeout has set the internal first-expiry flag and no `reload_wr` has occurred since. A reload in the same cycle as the timeout suppresses the second-expiry event. When reload and timeout coincide, the timeout still sets the flag.
- R6: When bit 1 goes from 0 to 1 with `reboot_inhibit` low, `plt_rst_req` is high for exactly 4 clocks, starting in the same cycle that bit 1 reads 1.
- R7: If `reboot_inhibit` is high in the cycle of the second expiry, bit 1 still sets but no reset request is issued.
- R8: Further second-expiry events while bit 1 is already 1 do not restart the request. After software clears bit 1, the next second expiry issues a new request.
- R9: Bit 0 latches a high level on `intrude_in`, two synchronizer clocks later. Writing 1 clears it. Only the RTC-well reset (`rtc_rst_n`) clears it, not the resume-well or platform reset.
- R10: When a set event and a write-1 clear reach the same bit in the same cycle, the bit ends at 1.
- R11: A platform reset clears the first-expiry flag, so the first timeout after it does not set bit 1.
- R12: A write with a data bit of 0 leaves the corresponding status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rtc_rst_n | input | 1 | RTC-well reset, active low |
| rsm_rst_n | input | 1 | Resume-well reset, active low |
| plt_rst_n | input | 1 | Platform reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data; 1 clears the matching sticky bit |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| reload_wr | input | 1 | Watchdog reload-write strobe |
| link_cmd_vld | input | 1 | Decoded management-link command valid |
| link_cmd_type | input | 8 | Decoded command-type field |
| noreboot_strap | input | 1 | No-reboot strap pin |
| pwr_good | input | 1 | Power-good signal |
| intrude_in | input | 1 | Chassis intrusion input |
| reboot_inhibit | input | 1 | No-reboot control; high blocks the reset request |
| rd_data | output | 16 | Register read value |
| plt_rst_req | output | 1 | Platform reset request pulse |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a 4-clock request pulse and command code 8'h08. With these values the pin-to-bit latency is short and fixed, so the cycle in which the strap and intrusion bits change can be predicted exactly. The request pulse is short enough that each clock of it, and its end, can be checked in a vector table. Directed sequences apply each of the three resets in turn, to show which bits survive each one and to show the flag loss that the platform reset causes.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int unsigned REG_W       = 16;
  localparam int unsigned BIT_INTRUDE = 0;
  localparam int unsigned BIT_SECOND  = 1;
  localparam int unsigned BIT_STRAP   = 2;
  localparam int unsigned BIT_SMI     = 4;

  typedef logic [REG_W-1:0] wdt2_word_t;

  localparam wdt2_word_t LIVE_MASK = wdt2_word_t'((1 << BIT_INTRUDE) | (1 << BIT_SECOND) |
                                                  (1 << BIT_STRAP)   | (1 << BIT_SMI));
  localparam wdt2_word_t RSVD_MASK = ~LIVE_MASK;
endpackage

// File: rtl/wdt2_rst_sync.sv
module wdt2_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/wdt2_sync.sv
module wdt2_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_nxt = d_i;
    end else begin : g_many
      always_comb stg_nxt = {stg_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_nxt;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wdt2_sticky.sv
module wdt2_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_nxt;
  logic q_en;

  always_comb begin
    q_en  = set_i | clr_i;
    q_nxt = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else if (q_en) begin
      q_q <= q_nxt;
    end
  end

  assign q_o = q_q;

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R10
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o)); // R12
endmodule

// File: rtl/wdt2_escalate.sv
module wdt2_escalate #(
  parameter int unsigned PULSE_LEN = 4,
  localparam int unsigned CNT_W    = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_rst_n,
  input  logic timeout_i,
  input  logic reload_i,
  input  logic inhibit_i,
  input  logic sts_i,
  output logic second_o,
  output logic req_o
);
  logic             first_q;
  logic             first_nxt;
  logic             first_en;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;
  logic             start;

  // first-expiry flag: a timeout sets it, a reload clears it, timeout wins
  always_comb begin
    first_en  = timeout_i | reload_i;
    first_nxt = timeout_i;
  end

  always_ff @(posedge clk or negedge flag_rst_n) begin
    if (!flag_rst_n) begin
      first_q <= 1'b0;
    end else if (first_en) begin
      first_q <= first_nxt;
    end
  end

  always_comb begin
    second_o = timeout_i & first_q & ~reload_i;
    start    = second_o & ~sts_i & ~inhibit_i;
    cnt_en   = start | (cnt_q != '0);
    if (start) begin
      cnt_nxt = CNT_W'(PULSE_LEN);
    end else begin
      cnt_nxt = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign req_o = (cnt_q != '0);

  AST_SECOND_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n || !flag_rst_n)
    second_o |=> sts_i); // R5
  AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> !$past(inhibit_i)); // R7
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> !$past(sts_i)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(PULSE_LEN)); // R6
endmodule

// File: rtl/wdt2_status.sv
module wdt2_status
  import wdt2_pkg::*;
#(
  parameter int unsigned CMD_W       = 8,
  parameter logic [7:0]  SMI_CMD     = 8'h08,
  parameter int unsigned PULSE_LEN   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rtc_rst_n,
  input  logic             rsm_rst_n,
  input  logic             plt_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wdt_timeout,
  input  logic             reload_wr,
  input  logic             link_cmd_vld,
  input  logic [CMD_W-1:0] link_cmd_type,
  input  logic             noreboot_strap,
  input  logic             pwr_good,
  input  logic             intrude_in,
  input  logic             reboot_inhibit,
  output logic [REG_W-1:0] rd_data,
  output logic             plt_rst_req
);
  localparam logic [CMD_W-1:0] SMI_CODE = CMD_W'(SMI_CMD);

  logic       rtc_rn;
  logic       rsm_rn;
  logic       plt_rn;
  logic       flag_rn;
  wdt2_word_t clr_vec;
  logic       smi_hit;
  logic       second_evt;
  logic       sts_smi;
  logic       sts_second;
  logic       sts_intrude;
  logic       intrude_s;
  logic       pg_s;
  logic       strap_s;
  logic       pg_prev_q;
  logic       strap_q;
  logic       strap_nxt;
  logic       pg_rise;
  logic       rsvd_write;

  // reset synchronizers, one per well
  wdt2_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_rtc (.clk(clk), .rst_in_n(rtc_rst_n), .rst_out_n(rtc_rn));
  wdt2_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_rsm (.clk(clk), .rst_in_n(rsm_rst_n), .rst_out_n(rsm_rn));
  wdt2_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_plt (.clk(clk), .rst_in_n(plt_rst_n), .rst_out_n(plt_rn));

  assign flag_rn = rsm_rn & plt_rn;

  // pin synchronizers
  wdt2_sync #(.STAGES(SYNC_STAGES)) u_sy_intr  (.clk(clk), .rst_n(rtc_rn), .d_i(intrude_in),     .q_o(intrude_s));
  wdt2_sync #(.STAGES(SYNC_STAGES)) u_sy_pg    (.clk(clk), .rst_n(rsm_rn), .d_i(pwr_good),       .q_o(pg_s));
  wdt2_sync #(.STAGES(SYNC_STAGES)) u_sy_strap (.clk(clk), .rst_n(rsm_rn), .d_i(noreboot_strap), .q_o(strap_s));

  always_comb begin
    clr_vec    = wr_en ? wr_data : '0;
    rsvd_write = wr_en & (|(wr_data & RSVD_MASK));
    smi_hit    = link_cmd_vld & (link_cmd_type == SMI_CODE);
  end

  // sticky status bits
  wdt2_sticky u_bit_smi (
    .clk(clk), .rst_n(rsm_rn), .set_i(smi_hit), .clr_i(clr_vec[BIT_SMI]), .q_o(sts_smi));
  wdt2_sticky u_bit_second (
    .clk(clk), .rst_n(rsm_rn), .set_i(second_evt), .clr_i(clr_vec[BIT_SECOND]), .q_o(sts_second));
  wdt2_sticky u_bit_intrude (
    .clk(clk), .rst_n(rtc_rn), .set_i(intrude_s), .clr_i(clr_vec[BIT_INTRUDE]), .q_o(sts_intrude));

  // second-expiry detection and reset request
  wdt2_escalate #(.PULSE_LEN(PULSE_LEN)) u_esc (
    .clk        (clk),
    .rst_n      (rsm_rn),
    .flag_rst_n (flag_rn),
    .timeout_i  (wdt_timeout),
    .reload_i   (reload_wr),
    .inhibit_i  (reboot_inhibit),
    .sts_i      (sts_second),
    .second_o   (second_evt),
    .req_o      (plt_rst_req)
  );

  // strap capture on power-good rising edge
  always_comb begin
    pg_rise   = pg_s & ~pg_prev_q;
    strap_nxt = strap_s;
  end

  always_ff @(posedge clk or negedge rsm_rn) begin
    if (!rsm_rn) begin
      pg_prev_q <= 1'b0;
    end else begin
      pg_prev_q <= pg_s;
    end
  end

  always_ff @(posedge clk or negedge rsm_rn) begin
    if (!rsm_rn) begin
      strap_q <= 1'b0;
    end else if (pg_rise) begin
      strap_q <= strap_nxt;
    end
  end

  always_comb begin
    rd_data              = '0;
    rd_data[BIT_SMI]     = sts_smi;
    rd_data[BIT_STRAP]   = strap_q;
    rd_data[BIT_SECOND]  = sts_second;
    rd_data[BIT_INTRUDE] = sts_intrude;
  end

  AST_STRAP_HOLDS: assert property (@(posedge clk) disable iff (!rsm_rn)
    !pg_rise |=> $stable(rd_data[BIT_STRAP])); // R4
  AST_RSVD_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rsm_rn || !rtc_rn)
    rsvd_write |=> ((rd_data & RSVD_MASK) == '0)); // R1
endmodule

// File: tb/wdt2_status_tb.sv
module wdt2_status_tb;
  localparam int CLK_P = 10;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rtc_rst_n, rsm_rst_n, plt_rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        wdt_timeout, reload_wr, link_cmd_vld;
  logic [7:0]  link_cmd_type;
  logic        noreboot_strap, pwr_good, intrude_in, reboot_inhibit;
  logic [15:0] rd_data;
  logic        plt_rst_req;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  wdt2_status u_dut (
    .clk(clk), .rtc_rst_n(rtc_rst_n), .rsm_rst_n(rsm_rst_n), .plt_rst_n(plt_rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .wdt_timeout(wdt_timeout), .reload_wr(reload_wr),
    .link_cmd_vld(link_cmd_vld), .link_cmd_type(link_cmd_type),
    .noreboot_strap(noreboot_strap), .pwr_good(pwr_good), .intrude_in(intrude_in),
    .reboot_inhibit(reboot_inhibit), .rd_data(rd_data), .plt_rst_req(plt_rst_req)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] wd;
    logic        tmo;
    logic        rld;
    logic        cv;
    logic [7:0]  ct;
    logic        inh;
    logic [15:0] erd;
    logic        ereq;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t TBL [NV] = '{
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0004,1'b0,4'd4},  // R4 strap held
    '{1'b0,16'h0000,1'b0,1'b0,1'b1,8'h07,1'b0,16'h0004,1'b0,4'd2},  // R2 other type
    '{1'b0,16'h0000,1'b0,1'b0,1'b1,8'h08,1'b0,16'h0014,1'b0,4'd2},  // R2 set
    '{1'b1,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0014,1'b0,4'd12}, // R12
    '{1'b1,16'hFFEC,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0014,1'b0,4'd1},  // R1
    '{1'b1,16'h0010,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0004,1'b0,4'd2},  // R2 clear
    '{1'b1,16'h0010,1'b0,1'b0,1'b1,8'h08,1'b0,16'h0014,1'b0,4'd10}, // R10
    '{1'b1,16'h0010,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0004,1'b0,4'd2},
    '{1'b0,16'h0000,1'b1,1'b0,1'b0,8'h00,1'b0,16'h0004,1'b0,4'd5},  // R5 first
    '{1'b0,16'h0000,1'b0,1'b1,1'b0,8'h00,1'b0,16'h0004,1'b0,4'd5},  // R5 reload
    '{1'b0,16'h0000,1'b1,1'b0,1'b0,8'h00,1'b0,16'h0004,1'b0,4'd5},  // R5 first again
    '{1'b0,16'h0000,1'b1,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b1,4'd6},  // R6 second
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b1,4'd6},
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b1,4'd6},
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b1,4'd6},
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b0,4'd6},  // R6 ends
    '{1'b0,16'h0000,1'b1,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b0,4'd8},  // R8
    '{1'b1,16'h0002,1'b1,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b0,4'd10}, // R10
    '{1'b1,16'h0002,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0004,1'b0,4'd5},
    '{1'b0,16'h0000,1'b1,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b1,4'd8},  // R8 new pulse
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b1,4'd6},
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b1,4'd6},
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b1,4'd6},
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b0,4'd6},
    '{1'b1,16'h0002,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0004,1'b0,4'd5},
    '{1'b0,16'h0000,1'b1,1'b0,1'b0,8'h00,1'b1,16'h0006,1'b0,4'd7},  // R7
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b0,4'd7},
    '{1'b1,16'h0002,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0004,1'b0,4'd5},
    '{1'b0,16'h0000,1'b1,1'b1,1'b0,8'h00,1'b0,16'h0004,1'b0,4'd5},  // R5 coincide
    '{1'b0,16'h0000,1'b1,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b1,4'd5},
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b1,4'd6},
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b1,4'd6},
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b1,4'd6},
    '{1'b0,16'h0000,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0006,1'b0,4'd6},
    '{1'b1,16'h0002,1'b0,1'b0,1'b0,8'h00,1'b0,16'h0004,1'b0,4'd5},
    '{1'b0,16'h0000,1'b0,1'b1,1'b0,8'h00,1'b0,16'h0004,1'b0,4'd5}
  };

  task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle_in();
    wr_en = 0; wr_data = '0; wdt_timeout = 0; reload_wr = 0;
    link_cmd_vld = 0; link_cmd_type = '0; reboot_inhibit = 0; intrude_in = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr1(input logic [15:0] d);
    wr_en = 1; wr_data = d; tick(1); idle_in();
  endtask

  task automatic tmo1();
    wdt_timeout = 1; tick(1); idle_in();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_in();
    rtc_rst_n = 0; rsm_rst_n = 0; plt_rst_n = 0;
    pwr_good = 0; noreboot_strap = 1;
    tick(3);
    rtc_rst_n = 1; rsm_rst_n = 1; plt_rst_n = 1;
    tick(4);
    check("R1 reset rd", rd_data, 16'h0000);
    check("R6 reset req", {15'b0, plt_rst_req}, 16'h0000);
    pwr_good = 1;
    tick(4);
    check("R4 strap capture", rd_data, 16'h0004);
    noreboot_strap = 0;
    tick(4);

    for (int v = 0; v < NV; v++) begin
      wr_en = TBL[v].wr; wr_data = TBL[v].wd; wdt_timeout = TBL[v].tmo;
      reload_wr = TBL[v].rld; link_cmd_vld = TBL[v].cv; link_cmd_type = TBL[v].ct;
      reboot_inhibit = TBL[v].inh;
      tick(1);
      check($sformatf("R%0d row %0d rd", TBL[v].rq, v), rd_data, TBL[v].erd);
      check($sformatf("R%0d row %0d req", TBL[v].rq, v), {15'b0, plt_rst_req}, {15'b0, TBL[v].ereq});
    end
    idle_in();

    // R9 intrusion latch
    intrude_in = 1; tick(1); intrude_in = 0;
    tick(4);
    check("R9 intrusion set", rd_data, 16'h0005);

    // set bits 4 and 1
    link_cmd_vld = 1; link_cmd_type = 8'h08; tick(1); idle_in();
    tmo1(); tmo1();
    check("R6 req on second", {15'b0, plt_rst_req}, 16'h0001);
    tick(6);
    check("R2 R5 bits set", rd_data, 16'h0017);

    // R3 platform reset keeps bits
    plt_rst_n = 0; tick(2); plt_rst_n = 1; tick(4);
    check("R3 survive platform reset", rd_data, 16'h0017);

    // R11 flag cleared by platform reset
    wr1(16'h0002);
    check("R11 cleared bit1", rd_data, 16'h0015);
    tmo1();
    check("R11 first after plt reset", rd_data, 16'h0015);
    tmo1();
    check("R5 second after plt reset", rd_data, 16'h0017);
    tick(6);

    // R3 resume reset clears 4,2,1 but not 0
    rsm_rst_n = 0; tick(2); rsm_rst_n = 1; tick(4);
    check("R3 R9 resume reset", rd_data, 16'h0001);

    wr1(16'h0001);
    check("R9 w1c", rd_data, 16'h0000);
    intrude_in = 1; tick(1); intrude_in = 0; tick(4);
    check("R9 relatch", rd_data, 16'h0001);
    rtc_rst_n = 0; tick(2); rtc_rst_n = 1; tick(4);
    check("R9 rtc reset", rd_data, 16'h0000);

    // R4 new power-good edge after resume reset
    pwr_good = 0; noreboot_strap = 1; tick(4);
    check("R4 no edge yet", rd_data, 16'h0000);
    pwr_good = 1; tick(4);
    check("R4 recapture", rd_data, 16'h0004);
    noreboot_strap = 0; wr1(16'h0004); tick(3);
    check("R4 read only", rd_data, 16'h0004);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule